// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs external bus cycles on a 16-bit address bus. The low address byte shares its wires with the 8-bit data bus. An internal requester presents a cycle type, an address and, for writes, a data byte. The controller then steps through the T-states of that cycle.

- In the first T-state it drives the address on both the high lines and the shared lines, with the latch-enable pulse high.
- It then turns the shared lines over to data and pulls the read or write strobe low.
- It holds that strobe while the READY input asks for wait states.
- It finishes in a last T-state and returns read data to the requester.

Status lines (IO/memory select plus two state bits) tell external logic which kind of cycle is running.

An external master can ask for the bus with HOLD. The controller first finishes any cycle in progress. It then raises HLDA and turns off three separate output enables: one for the high address lines, one for the shared lines and one for the control lines. It takes the bus back one clock after HOLD falls. An active-low reset floats every bus output and clears the held address to 0000h. Each T-state is one clock.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: While rst_n is low, and for one clock after it rises, the outputs are as follows: all three output enables are 0, hlda is 0, ale is 0, both strobes are high and the status is 000. In the first idle cycle after reset, addr_hi reads 00h.
- R2: Acceptance of a request:
  - req_ready is 1 exactly when the controller is idle and hold is 0.
  - A request with req_valid and req_ready high at a rising edge is accepted, and its T1 occupies the next clock.
  - While idle, the high address lines and the control lines are driven, the shared lines are released, and both strobes are high.
- R3: In T1, ale is 1 for that clock only. addr_hi carries address bits 15:8, and ad_out carries bits 7:0 with ad_oe at 1. Both strobes are high.
- R4: From T2 through T3, including any wait states, ale is 0.
  - Read-type cycles hold rd_n low and wr_n high, with ad_oe at 0.
  - Write cycles (types 1 and 3) hold wr_n low and rd_n high, and drive the write data on ad_out with ad_oe at 1.
  - rd_n and wr_n are never both low.
- R5: During T1 to T3 the status {iom,s1,s0} follows the cycle type, and it stays constant for the whole cycle. In every other state it is 000. The type codes and their status values are:
  - 0, memory read: 010
  - 1, memory write: 001
  - 2, I/O read: 110
  - 3, I/O write: 101
  - 4, opcode fetch: 011
  - 5, interrupt acknowledge: 111
- R6: READY is sampled at the clock edge that ends T2 and at the edge that ends each wait state. Each low sample adds one more wait clock with the strobe unchanged. A high sample moves to T3.
- R7: On the edge that ends T3, rsp_valid rises for exactly one clock. rsp_rdata takes ad_in for read-type cycles and 00h for write cycles, and keeps that value until the next completion.
- R8: HOLD never cuts a cycle short. If hold is 1 at the edge that ends T3, or at any idle edge, the next state is the hold state. In the hold state hlda is 1 and all three output enables are 0.
- R9: hlda falls one clock after hold is sampled low, and the controller is then idle with its drivers enabled. A request waiting during hold is accepted no earlier than that idle clock.
- R10: Reserved type codes 6 and 7 run as memory reads: status 010, rd_n strobe, read data returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cycle request present |
| req_type | input | 3 | Cycle type code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller can accept a request |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Data captured at end of T3 |
| addr_hi | output | 8 | High address lines |
| addr_hi_oe | output | 1 | Output enable for addr_hi |
| ad_out | output | 8 | Shared address/data lines, driven value |
| ad_oe | output | 1 | Output enable for the shared lines |
| ad_in | input | 8 | Shared lines, sampled value |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| iom | output | 1 | 1 for I/O and interrupt-acknowledge cycles, 0 for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| ctrl_oe | output | 1 | Output enable for strobes, ale and status |
| ready | input | 1 | Wait-state request, low inserts a wait |
| hold | input | 1 | Bus request from an external master |
| hlda | output | 1 | Bus grant acknowledge |

## Verification
Every bus output is a direct decode of the registered T-state, so it settles one clock after the edge that moved the state. This means T1 appears one clock after acceptance, each READY low sample pushes T3 back by one clock, and hlda rises one clock after T3 or an idle edge that saw hold. The completion pulse and the read data are registered on the edge that leaves T3, so they appear in the clock after T3. The bench advances its own phase model on each rising edge, using the same inputs the design samples there. It compares every output at the following falling edge, after which the shifted timings above hold without any special-case delays.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  localparam logic [2:0] CYC_MRD  = 3'd0;
  localparam logic [2:0] CYC_MWR  = 3'd1;
  localparam logic [2:0] CYC_IORD = 3'd2;
  localparam logic [2:0] CYC_IOWR = 3'd3;
  localparam logic [2:0] CYC_OPF  = 3'd4;
  localparam logic [2:0] CYC_INTA = 3'd5;

  typedef enum logic [2:0] {
    TS_RST, TS_IDLE, TS_T1, TS_T2, TS_TW, TS_T3, TS_HOLD
  } tstate_e;

  // {iom, s1, s0} for a cycle type; reserved codes behave as memory read
  function automatic logic [2:0] status_code(input logic [2:0] t);
    case (t)
      CYC_MWR:  return 3'b001;
      CYC_IORD: return 3'b110;
      CYC_IOWR: return 3'b101;
      CYC_OPF:  return 3'b011;
      CYC_INTA: return 3'b111;
      default:  return 3'b010;
    endcase
  endfunction

  function automatic logic is_write(input logic [2:0] t);
    return (t == CYC_MWR) || (t == CYC_IOWR);
  endfunction

endpackage

// File: rtl/mbus_tseq.sv
module mbus_tseq
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ready,
  input  logic              hold,
  output tstate_e           state,
  output logic [2:0]        cur_type,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic              req_ready
);

  tstate_e nxt;
  logic    accept;

  assign req_ready = (state == TS_IDLE) && !hold;
  assign accept    = req_ready && req_valid;

  always_comb begin
    nxt = state;
    case (state)
      TS_RST:  nxt = TS_IDLE;
      TS_IDLE: if (hold) nxt = TS_HOLD;
               else if (req_valid) nxt = TS_T1;
      TS_T1:   nxt = TS_T2;
      TS_T2:   nxt = ready ? TS_T3 : TS_TW;
      TS_TW:   nxt = ready ? TS_T3 : TS_TW;
      TS_T3:   nxt = hold ? TS_HOLD : TS_IDLE;
      TS_HOLD: nxt = hold ? TS_HOLD : TS_IDLE;
      default: nxt = TS_RST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= TS_RST;
      cur_type  <= CYC_MRD;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else begin
      state <= nxt;
      if (accept) begin
        cur_type  <= req_type;
        cur_addr  <= req_addr;
        cur_wdata <= req_wdata;
      end
    end
  end

endmodule

// File: rtl/mbus_pindrv.sv
module mbus_pindrv
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  tstate_e           state,
  input  logic [2:0]        cur_type,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  output logic [HI_W-1:0]   addr_hi,
  output logic              addr_hi_oe,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              iom,
  output logic              s1,
  output logic              s0,
  output logic              ctrl_oe,
  output logic              hlda
);

  logic in_cycle, in_data, wr_cyc;

  assign in_cycle = (state == TS_T1) || in_data;
  assign in_data  = (state == TS_T2) || (state == TS_TW) || (state == TS_T3);
  assign wr_cyc   = is_write(cur_type);

  assign addr_hi        = cur_addr[ADDR_W-1:DATA_W];
  assign addr_hi_oe     = (state != TS_RST) && (state != TS_HOLD);
  assign ctrl_oe        = addr_hi_oe;
  assign hlda           = (state == TS_HOLD);
  assign ale            = (state == TS_T1);
  assign ad_oe          = ale || (in_data && wr_cyc);
  assign ad_out         = ale ? cur_addr[DATA_W-1:0] : (in_data ? cur_wdata : '0);
  assign rd_n           = !(in_data && !wr_cyc);
  assign wr_n           = !(in_data && wr_cyc);
  assign {iom, s1, s0}  = in_cycle ? status_code(cur_type) : 3'b000;

endmodule

// File: rtl/mbus_rdcap.sv
module mbus_rdcap
  import mbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tstate_e           state,
  input  logic [2:0]        cur_type,
  input  logic [DATA_W-1:0] ad_in,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic finish;
  assign finish = (state == TS_T3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= finish;
      if (finish) rsp_rdata <= is_write(cur_type) ? '0 : ad_in;
    end
  end

endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [HI_W-1:0]   addr_hi,
  output logic              addr_hi_oe,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              iom,
  output logic              s1,
  output logic              s0,
  output logic              ctrl_oe,
  input  logic              ready,
  input  logic              hold,
  output logic              hlda
);

  tstate_e           state;
  logic [2:0]        cur_type;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;

  // named phase events, used by the bound checker
  logic ev_t2w, ev_mid, ev_t3;
  assign ev_t2w = (state == TS_T2) || (state == TS_TW);
  assign ev_mid = ev_t2w || (state == TS_T3);
  assign ev_t3  = (state == TS_T3);

  mbus_tseq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .hold(hold),
    .state(state), .cur_type(cur_type), .cur_addr(cur_addr),
    .cur_wdata(cur_wdata), .req_ready(req_ready)
  );

  mbus_pindrv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .state(state), .cur_type(cur_type), .cur_addr(cur_addr),
    .cur_wdata(cur_wdata), .addr_hi(addr_hi), .addr_hi_oe(addr_hi_oe),
    .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .iom(iom), .s1(s1), .s0(s0), .ctrl_oe(ctrl_oe), .hlda(hlda)
  );

  mbus_rdcap #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .state(state), .cur_type(cur_type),
    .ad_in(ad_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

endmodule

// File: rtl/mbus_cycle_ctrl_chk.sv
module mbus_cycle_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe,
  input logic addr_hi_oe,
  input logic ctrl_oe,
  input logic hlda,
  input logic hold,
  input logic ready,
  input logic iom,
  input logic s1,
  input logic s0,
  input logic rsp_valid,
  input logic ev_t2w,
  input logic ev_mid,
  input logic ev_t3
);

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n || wr_n);

  p_float_on_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> !(ad_oe || addr_hi_oe || ctrl_oe));

  p_ale_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && (!rd_n || !wr_n)));

  p_wait_keeps_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_t2w && !ready) |=> (ev_t2w && $stable({rd_n, wr_n})));

  p_status_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mid |-> $stable({iom, s1, s0}));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_t3 |=> rsp_valid);

  p_no_grant_midcycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mid |-> !hlda);

  p_grant_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && !hold) |=> !hlda);

endmodule

bind mbus_cycle_ctrl mbus_cycle_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .ad_oe(ad_oe), .addr_hi_oe(addr_hi_oe), .ctrl_oe(ctrl_oe), .hlda(hlda),
  .hold(hold), .ready(ready), .iom(iom), .s1(s1), .s0(s0),
  .rsp_valid(rsp_valid), .ev_t2w(ev_t2w), .ev_mid(ev_mid), .ev_t3(ev_t3)
);

// File: tb/mbus_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module mbus_cycle_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_type = 3'd0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0] req_wdata = 8'h0;
  logic       req_ready, rsp_valid;
  logic [7:0] rsp_rdata, addr_hi, ad_out;
  logic [7:0] ad_in = 8'h00;
  logic       addr_hi_oe, ad_oe, ale, rd_n, wr_n, iom, s1, s0, ctrl_oe, hlda;
  logic       ready = 1'b1;
  logic       hold = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_cycle_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .addr_hi(addr_hi),
    .addr_hi_oe(addr_hi_oe), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .iom(iom), .s1(s1), .s0(s0),
    .ctrl_oe(ctrl_oe), .ready(ready), .hold(hold), .hlda(hlda)
  );

  int checks = 0;
  int fails  = 0;
  int wait_left = 0;
  int cyc = 0;

  // reference model, phase: 0 reset, 1 idle, 2 addr, 3 strobe, 4 wait, 5 last, 6 granted
  int         m_phase = 0;
  int         m_prev  = 0;
  int         m_type  = 0;
  logic [15:0] m_addr = 16'h0;
  logic [7:0] m_wd = 8'h0;
  logic       m_rsp = 1'b0;
  logic [7:0] m_rd = 8'h0;

  function automatic logic [2:0] stat_of(int t);
    logic [2:0] tab [0:7];
    tab = '{3'b010, 3'b001, 3'b110, 3'b101, 3'b011, 3'b111, 3'b010, 3'b010};
    return tab[t];
  endfunction

  function automatic bit wr_kind(int t);
    return (t == 1) || (t == 3);
  endfunction

  always @(posedge clk) begin
    m_prev <= m_phase;
    if (!rst_n) begin
      m_phase <= 0; m_addr <= 16'h0; m_type <= 0; m_wd <= 8'h0;
      m_rsp <= 1'b0; m_rd <= 8'h0;
    end else begin
      m_rsp <= (m_phase == 5);
      if (m_phase == 5) m_rd <= wr_kind(m_type) ? 8'h00 : ad_in;
      case (m_phase)
        0: m_phase <= 1;
        1: if (hold) m_phase <= 6;
           else if (req_valid) begin
             m_phase <= 2; m_type <= int'(req_type);
             m_addr <= req_addr; m_wd <= req_wdata;
           end
        2: m_phase <= 3;
        3, 4: m_phase <= ready ? 5 : 4;
        5: m_phase <= hold ? 6 : 1;
        default: m_phase <= hold ? 6 : 1;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic string phase_tag(int p, int prev);
    case (p)
      0: return "R1";
      1: return (prev == 6) ? "R9" : ((prev == 0) ? "R1" : "R2");
      2: return "R3";
      4: return "R6";
      6: return "R8";
      default: return "R4";
    endcase
  endfunction

  always @(negedge clk) begin
    string tg, st;
    bit drv, inc, mid, w;
    logic [2:0] es, as;
    tg  = phase_tag(m_phase, m_prev);
    drv = (m_phase != 0) && (m_phase != 6);
    mid = (m_phase >= 3) && (m_phase <= 5);
    inc = (m_phase == 2) || mid;
    w   = wr_kind(m_type);
    chk(addr_hi_oe == drv, tg, "addr_hi_oe", addr_hi_oe, drv);
    chk(ctrl_oe == drv, tg, "ctrl_oe", ctrl_oe, drv);
    chk(hlda == (m_phase == 6), tg, "hlda", hlda, m_phase == 6);
    chk(ale == (m_phase == 2), tg, "ale", ale, m_phase == 2);
    chk(ad_oe == ((m_phase == 2) || (mid && w)), tg, "ad_oe", ad_oe,
        (m_phase == 2) || (mid && w));
    chk(rd_n == !(mid && !w), tg, "rd_n", rd_n, !(mid && !w));
    chk(wr_n == !(mid && w), tg, "wr_n", wr_n, !(mid && w));
    if (m_phase == 1 || m_phase == 2)
      chk(addr_hi == m_addr[15:8], tg, "addr_hi", addr_hi, m_addr[15:8]);
    if (m_phase == 2)
      chk(ad_out == m_addr[7:0], "R3", "ad_out addr", ad_out, m_addr[7:0]);
    if (mid && w)
      chk(ad_out == m_wd, "R4", "ad_out wdata", ad_out, m_wd);
    es = inc ? stat_of(m_type) : 3'b000;
    as = {iom, s1, s0};
    st = (inc && m_type >= 6) ? "R10" : "R5";
    chk(as == es, st, "status", as, es);
    chk(req_ready == (m_phase == 1 && !hold), "R2", "req_ready", req_ready,
        m_phase == 1 && !hold);
    chk(rsp_valid == m_rsp, (m_type >= 6) ? "R10" : "R7", "rsp_valid", rsp_valid, m_rsp);
    chk(rsp_rdata == m_rd, (m_type >= 6) ? "R10" : "R7", "rsp_rdata", rsp_rdata, m_rd);
    if ((m_phase == 3 || m_phase == 4) && wait_left > 0) begin
      ready = 1'b0; wait_left--;
    end else ready = 1'b1;
  end

  task automatic issue(input int t, input logic [15:0] a, input logic [7:0] wd,
                       input logic [7:0] rdv, input int waits);
    @(negedge clk); #1;
    ad_in = rdv; wait_left = waits;
    req_valid = 1'b1; req_type = 3'(t); req_addr = a; req_wdata = wd;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    req_valid = 1'b0;
    while (!(m_phase == 1 || m_phase == 6)) begin @(negedge clk); #1; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1 chk(addr_hi == 8'h00 && addr_hi_oe, "R1", "addr after reset", addr_hi, 0);
    // all six types, no waits
    issue(0, 16'h1234, 8'h00, 8'hA5, 0);
    issue(1, 16'hBEEF, 8'h3C, 8'h00, 0);
    issue(2, 16'h0042, 8'h00, 8'h5A, 0);
    issue(3, 16'h00F0, 8'hC3, 8'h00, 0);
    issue(4, 16'h8001, 8'h00, 8'h76, 0);
    issue(5, 16'hFFFF, 8'h00, 8'hEF, 0);
    // wait states (R6)
    issue(0, 16'h2000, 8'h00, 8'h11, 2);
    issue(3, 16'h0077, 8'h99, 8'h00, 3);
    issue(4, 16'h0100, 8'h00, 8'h22, 1);
    // reserved codes (R10)
    issue(6, 16'h4321, 8'h55, 8'h66, 0);
    issue(7, 16'h9876, 8'hAA, 8'h77, 1);
    // hold while idle, then a request waiting through the grant (R8, R9)
    @(negedge clk); #1 hold = 1'b1;
    repeat (4) @(negedge clk);
    fork
      issue(1, 16'hC0DE, 8'h5E, 8'h00, 0);
      begin repeat (3) @(negedge clk); #2 hold = 1'b0; end
    join
    // hold raised mid-cycle (R8)
    fork
      issue(0, 16'h7A7A, 8'h00, 8'h88, 2);
      begin
        while (m_phase != 3) begin @(negedge clk); #2; end
        hold = 1'b1;
        repeat (6) @(negedge clk);
        #2 hold = 1'b0;
      end
    join
    repeat (3) @(negedge clk);
    issue(2, 16'h0033, 8'h00, 8'h44, 0);
    // reset in the middle of a cycle (R1)
    @(negedge clk); #1;
    req_valid = 1'b1; req_type = 3'd1; req_addr = 16'h5555; req_wdata = 8'h12;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b0; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk(addr_hi == 8'h00, "R1", "addr cleared", addr_hi, 0);
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule